// File: doc/BRIEF.md
# Two-Instruction-Word Fetch-Execute Controller

This block sequences a single-accumulator machine whose 40-bit memory words each carry two 20-bit instructions. It holds its own program counter, memory address and buffer registers, an instruction register, a buffer for the second instruction of a word, the accumulator and a multiplier-quotient register. It drives a synchronous word-wide memory port and reports its register contents on debug outputs.

One memory read fetches both instructions. The left instruction runs first. The right instruction is then moved from the buffer register into the instruction register and runs without a second read. The program counter advances only after the right instruction is done. A taken jump drops any right instruction still waiting and continues at the target word.

Each instruction moves through a named state sequence. The fetch path is `ST_FETCH` (the address register takes the program counter), then `ST_FREAD` (the memory samples the address), then `ST_FLOAD` (the buffer, instruction and buffered-instruction registers are loaded). Next comes `ST_DECODE` (the address register takes the operand address). From there the operand path is `ST_OREAD`, then `ST_OLOAD`, then `ST_EXEC`. A store goes to `ST_STORE`. A jump is resolved in `ST_DECODE` itself. Halt and unknown opcodes go to `ST_HALT`, which the block leaves only on reset. When an instruction completes, the next state is `ST_DECODE` if the right instruction is still to run, and `ST_FETCH` otherwise.

Top module: `twin_instr_cpu`

## Requirements
- R1: Reset clears the program counter, accumulator, multiplier-quotient, memory address, memory buffer, instruction and buffered-instruction registers. With reset applied, `halt` and `mem_we` are low, and the first fetch after reset reads word 0.
- R2: A word is split into two 20-bit instructions. The left one, bits [39:20], holds its opcode in [39:32] and its address in [31:20]. The right one, bits [19:0], holds its opcode in [19:12] and its address in [11:0]. The left instruction executes before the right one.
- R3: The right instruction runs from the buffer register as it was fetched. A store by the left instruction into the word being executed does not change the right instruction.
- R4: After the right instruction completes without a taken jump, the program counter advances by one, wrapping from 4095 to 0.
- R5: Opcode 0x01 loads the addressed word into the accumulator. Opcode 0x02 writes the accumulator to the addressed word: `mem_we` is high for one cycle, with `mem_addr` set to the target and `mem_wdata` set to the accumulator.
- R6: Opcode 0x03 adds the addressed word to the accumulator and opcode 0x04 subtracts it. Both use two's complement, modulo 2^40.
- R7: Opcode 0x05 multiplies the accumulator by the addressed word as signed numbers. The upper 40 bits of the 80-bit product go to the accumulator and the lower 40 bits to the multiplier-quotient register. No other opcode changes the multiplier-quotient register.
- R8: Opcode 0x06 sets the program counter to its address field and discards any pending right instruction.
- R9: Opcode 0x07 jumps like 0x06 when accumulator bit 39 is 0. Otherwise execution continues normally.
- R10: Opcode 0x00, and any opcode not listed above, raises `halt`. `halt` stays high until reset, no further memory write happens, and the program counter keeps the address of the word holding that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_addr | output | 12 | Memory address (memory address register) |
| mem_rdata | input | 40 | Read data, valid one clock after the address |
| mem_wdata | output | 40 | Write data |
| mem_we | output | 1 | Write enable |
| halt | output | 1 | Machine stopped |
| dbg_pc | output | 12 | Program counter view |
| dbg_ac | output | 40 | Accumulator view |
| dbg_mq | output | 40 | Multiplier-quotient view |
| dbg_ir | output | 20 | Instruction register view |
| dbg_ibr | output | 20 | Buffered right-instruction view |
| dbg_mbr | output | 40 | Memory buffer register view |

## Verification
Seven short programs are compared against an instruction-level model in the bench, which predicts every memory write and the final registers. An arithmetic chain tells apart left-before-right ordering, and a signed multiply with negative and wide operands tells apart the high and low product halves. A program that overwrites its own word shows whether the right instruction comes from the buffer or from a re-read. Jumps placed in the left and right slots, conditional jumps on negative and zero values, a wrap from word 4095 back to 0, and an unknown opcode separate a discarded right instruction from an executed one, and a stepped program counter from a held one.

// File: rtl/twin_pkg.sv
package twin_pkg;
    localparam int OPC_W  = 8;
    localparam int ADR_W  = 12;
    localparam int SLOTS  = 2;
    localparam int INS_W  = OPC_W + ADR_W;
    localparam int WORD_W = SLOTS * INS_W;
    localparam int PROD_W = 2 * WORD_W;

    localparam logic [OPC_W-1:0] OPC_HALT  = 8'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [OPC_W-1:0] OPC_STORE = 8'h02;
    localparam logic [OPC_W-1:0] OPC_ADD   = 8'h03;
    localparam logic [OPC_W-1:0] OPC_SUB   = 8'h04;
    localparam logic [OPC_W-1:0] OPC_MUL   = 8'h05;
    localparam logic [OPC_W-1:0] OPC_JMP   = 8'h06;
    localparam logic [OPC_W-1:0] OPC_JGE   = 8'h07;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [ADR_W-1:0] adr;
    } instr_t;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_FREAD,
        ST_FLOAD,
        ST_DECODE,
        ST_OREAD,
        ST_OLOAD,
        ST_EXEC,
        ST_STORE,
        ST_HALT
    } state_t;
endpackage

// File: rtl/twin_alu.sv
module twin_alu
    import twin_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] opd,
    output logic [WORD_W-1:0] acc_nxt,
    output logic [WORD_W-1:0] mq_nxt,
    output logic              mq_load
);
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod    = PROD_W'($signed(acc)) * PROD_W'($signed(opd));
        acc_nxt = acc;
        mq_nxt  = prod[WORD_W-1:0];
        mq_load = 1'b0;
        case (opc)
            OPC_LOAD: acc_nxt = opd;
            OPC_ADD:  acc_nxt = acc + opd;
            OPC_SUB:  acc_nxt = acc - opd;
            OPC_MUL: begin
                acc_nxt = prod[PROD_W-1:WORD_W];
                mq_load = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/twin_split.sv
module twin_split
    import twin_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            left_ins,
    output instr_t            right_ins
);
    instr_t slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot[g] = instr_t'(word[g*INS_W +: INS_W]);
    end

    // the most significant half runs first
    assign left_ins  = slot[SLOTS-1];
    assign right_ins = slot[0];
endmodule

// File: rtl/twin_instr_cpu.sv
module twin_instr_cpu
    import twin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halt,
    output logic [ADR_W-1:0]  dbg_pc,
    output logic [WORD_W-1:0] dbg_ac,
    output logic [WORD_W-1:0] dbg_mq,
    output logic [INS_W-1:0]  dbg_ir,
    output logic [INS_W-1:0]  dbg_ibr,
    output logic [WORD_W-1:0] dbg_mbr
);
    state_t            state, state_nxt;
    logic [ADR_W-1:0]  pc, mar;
    logic [WORD_W-1:0] mbr, ac, mq;
    instr_t            ir, ibr;
    logic              in_right;

    instr_t            w_left, w_right;
    logic [WORD_W-1:0] alu_acc, alu_mq;
    logic              alu_mq_ld;

    logic is_operand, is_branch, jump_take, fin;

    twin_split u_split (
        .word      (mem_rdata),
        .left_ins  (w_left),
        .right_ins (w_right)
    );

    twin_alu u_alu (
        .opc     (ir.opc),
        .acc     (ac),
        .opd     (mbr),
        .acc_nxt (alu_acc),
        .mq_nxt  (alu_mq),
        .mq_load (alu_mq_ld)
    );

    assign is_operand = (ir.opc == OPC_LOAD) || (ir.opc == OPC_ADD) ||
                        (ir.opc == OPC_SUB)  || (ir.opc == OPC_MUL);
    assign is_branch  = (ir.opc == OPC_JMP) || (ir.opc == OPC_JGE);
    assign jump_take  = (ir.opc == OPC_JMP) ||
                        ((ir.opc == OPC_JGE) && !ac[WORD_W-1]);
    assign fin = (state == ST_EXEC) || (state == ST_STORE) ||
                 ((state == ST_DECODE) && is_branch && !jump_take);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH:  state_nxt = ST_FREAD;
            ST_FREAD:  state_nxt = ST_FLOAD;
            ST_FLOAD:  state_nxt = ST_DECODE;
            ST_DECODE: begin
                if (is_operand)               state_nxt = ST_OREAD;
                else if (ir.opc == OPC_STORE) state_nxt = ST_STORE;
                else if (is_branch)
                    state_nxt = (jump_take || in_right) ? ST_FETCH : ST_DECODE;
                else                          state_nxt = ST_HALT;
            end
            ST_OREAD:  state_nxt = ST_OLOAD;
            ST_OLOAD:  state_nxt = ST_EXEC;
            ST_EXEC,
            ST_STORE:  state_nxt = in_right ? ST_FETCH : ST_DECODE;
            ST_HALT:   state_nxt = ST_HALT;
            default:   state_nxt = ST_HALT;
        endcase
    end

    // register transfers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pc       <= '0;
            mar      <= '0;
            mbr      <= '0;
            ac       <= '0;
            mq       <= '0;
            ir       <= '0;
            ibr      <= '0;
            in_right <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: mar <= pc;
                ST_FLOAD: begin
                    mbr      <= mem_rdata;
                    ir       <= w_left;
                    ibr      <= w_right;
                    in_right <= 1'b0;
                end
                ST_DECODE: begin
                    mar <= ir.adr;
                    if (is_branch && jump_take) begin
                        pc       <= ir.adr;
                        in_right <= 1'b0;
                    end
                end
                ST_OLOAD: mbr <= mem_rdata;
                ST_EXEC: begin
                    ac <= alu_acc;
                    if (alu_mq_ld) mq <= alu_mq;
                end
                default: ;
            endcase
            if (fin) begin
                if (in_right) begin
                    pc       <= pc + 1'b1;
                    in_right <= 1'b0;
                end else begin
                    ir       <= ibr;
                    in_right <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = mar;
        mem_wdata = ac;
        mem_we    = (state == ST_STORE);
        halt      = (state == ST_HALT);
        dbg_pc    = pc;
        dbg_ac    = ac;
        dbg_mq    = mq;
        dbg_ir    = ir;
        dbg_ibr   = ibr;
        dbg_mbr   = mbr;
    end
endmodule

// File: rtl/twin_instr_chk.sv
module twin_instr_chk
    import twin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic              mem_we,
    input logic [ADR_W-1:0]  mem_addr,
    input logic [ADR_W-1:0]  dbg_pc,
    input logic [INS_W-1:0]  dbg_ir,
    input logic [WORD_W-1:0] dbg_mq
);
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

    p_store_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_store_target_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == dbg_ir[ADR_W-1:0]) &&
                   (dbg_ir[INS_W-1:ADR_W] == OPC_STORE));

    p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
        (dbg_pc != $past(dbg_pc)) |->
            ((dbg_pc == $past(dbg_pc) + 1'b1) || (dbg_pc == $past(dbg_ir[ADR_W-1:0]))));

    p_mq_mul_only_r7: assert property (@(posedge clk) disable iff (rst)
        (dbg_mq != $past(dbg_mq)) |-> ($past(dbg_ir[INS_W-1:ADR_W]) == OPC_MUL));
endmodule

bind twin_instr_cpu twin_instr_chk u_twin_instr_chk (
    .clk      (clk),
    .rst      (rst),
    .halt     (halt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .dbg_pc   (dbg_pc),
    .dbg_ir   (dbg_ir),
    .dbg_mq   (dbg_mq)
);

// File: tb/test_twin_instr_cpu.sv
module test_twin_instr_cpu;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYC     = 3000;

    localparam logic [7:0] B_HALT = 8'h00, B_LOAD = 8'h01, B_STORE = 8'h02,
                           B_ADD = 8'h03, B_SUB = 8'h04, B_MUL = 8'h05,
                           B_JMP = 8'h06, B_JGE = 8'h07, B_BAD = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [39:0] mem_rdata;
    logic [39:0] mem_wdata;
    logic        mem_we;
    logic        halt;
    logic [11:0] dbg_pc;
    logic [39:0] dbg_ac, dbg_mq, dbg_mbr;
    logic [19:0] dbg_ir, dbg_ibr;

    always #(CLK_PERIOD/2) clk = ~clk;

    twin_instr_cpu i_twin_instr_cpu (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halt(halt), .dbg_pc(dbg_pc),
        .dbg_ac(dbg_ac), .dbg_mq(dbg_mq), .dbg_ir(dbg_ir), .dbg_ibr(dbg_ibr),
        .dbg_mbr(dbg_mbr)
    );

    // synchronous memory model with a bench load port
    logic [39:0] mem [0:4095];
    logic        ld_en = 1'b0;
    logic [11:0] ld_a  = '0;
    logic [39:0] ld_d  = '0;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // golden state and scoreboard
    logic [39:0] gm [0:4095];
    logic [51:0] exp_q [$];
    logic [39:0] exp_ac, exp_mq;
    logic [11:0] exp_pc;
    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [39:0] mk(input logic [7:0] ol, input logic [11:0] al,
                                       input logic [7:0] orr, input logic [11:0] ar);
        return {ol, al, orr, ar};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [39:0] d);
        gm[a] = d;
        @(negedge clk);
        ld_en = 1'b1; ld_a = a; ld_d = d;
    endtask

    task automatic put_done();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // driver side: instruction-level model pushes expected writes
    task automatic model_run();
        logic [11:0] pc;
        logic [39:0] ac, mq, w;
        logic [19:0] ins;
        logic [7:0]  op;
        logic [11:0] a;
        logic signed [79:0] p;
        bit stop, jumped;
        pc = '0; ac = '0; mq = '0; stop = 0;
        for (int step = 0; step < 400 && !stop; step++) begin
            w = gm[pc];
            jumped = 0;
            for (int s = 0; s < 2 && !stop && !jumped; s++) begin
                ins = (s == 0) ? w[39:20] : w[19:0];
                op = ins[19:12];
                a  = ins[11:0];
                case (op)
                    B_LOAD:  ac = gm[a];
                    B_STORE: begin gm[a] = ac; exp_q.push_back({a, ac}); end
                    B_ADD:   ac = ac + gm[a];
                    B_SUB:   ac = ac - gm[a];
                    B_MUL: begin
                        p  = 80'($signed(ac)) * 80'($signed(gm[a]));
                        ac = p[79:40];
                        mq = p[39:0];
                    end
                    B_JMP:   begin pc = a; jumped = 1; end
                    B_JGE:   if (!ac[39]) begin pc = a; jumped = 1; end
                    default: stop = 1;
                endcase
            end
            if (!stop && !jumped) pc = pc + 1'b1;
        end
        exp_ac = ac; exp_mq = mq; exp_pc = pc;
    endtask

    // monitor side: pop and compare each write the design makes
    task automatic mon_write();
        logic [51:0] it;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5/R10: actual write %h at %h expected none", mem_wdata, mem_addr);
        end else begin
            it = exp_q.pop_front();
            chk("R5 store addr/data", 64'({mem_addr, mem_wdata}), 64'(it));
        end
    endtask

    task automatic run_prog(input string nm);
        int  cyc;
        bit  done;
        model_run();
        @(negedge clk);
        rst = 1'b0;
        cyc = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (mem_we) mon_write();
            if (halt) done = 1;
            else if (cyc > WD_CYC) begin
                n_cmp++; n_bad++;
                $display("FAIL R10 %s: actual no halt after %0d cycles expected halt", nm, cyc);
                done = 1;
            end
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (mem_we) mon_write();
        end
        chk({"R10 halt held ", nm}, 64'(halt), 64'(1));
        chk({"R4/R10 pc ", nm}, 64'(dbg_pc), 64'(exp_pc));
        chk({"R6 ac ", nm}, 64'(dbg_ac), 64'(exp_ac));
        chk({"R7 mq ", nm}, 64'(dbg_mq), 64'(exp_mq));
        chk({"R5 writes left ", nm}, 64'(exp_q.size()), 64'(0));
        exp_q.delete();
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset(input string nm);
        @(negedge clk);
        chk({"R1 pc ", nm}, 64'(dbg_pc), 64'(0));
        chk({"R1 ac ", nm}, 64'(dbg_ac), 64'(0));
        chk({"R1 mq ", nm}, 64'(dbg_mq), 64'(0));
        chk({"R1 ir/ibr ", nm}, 64'({dbg_ir, dbg_ibr}), 64'(0));
        chk({"R1 mbr ", nm}, 64'(dbg_mbr), 64'(0));
        chk({"R1 addr/we/halt ", nm}, 64'({mem_addr, mem_we, halt}), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset("power-up");

        // R2 R6: ordering and add/subtract chain
        put(0, mk(B_LOAD, 100, B_ADD, 101));
        put(1, mk(B_STORE, 200, B_SUB, 102));
        put(2, mk(B_STORE, 201, B_HALT, 0));
        put(100, 40'd5);
        put(101, 40'd7);
        put(102, 40'd20);
        put_done();
        run_prog("arith");

        // R7: signed multiply, negative and wide operands
        put(0, mk(B_LOAD, 110, B_MUL, 111));
        put(1, mk(B_STORE, 210, B_LOAD, 113));
        put(2, mk(B_MUL, 114, B_STORE, 211));
        put(3, mk(B_HALT, 0, B_HALT, 0));
        put(110, -40'd3);
        put(111, 40'd7);
        put(113, 40'h40_0000_0005);
        put(114, 40'h00_0000_0403);
        put_done();
        run_prog("mul");
        check_reset("after run");

        // R3: left store overwrites its own word; right must still run
        put(0, mk(B_STORE, 0, B_LOAD, 120));
        put(1, mk(B_STORE, 220, B_HALT, 0));
        put(120, 40'h77);
        put_done();
        run_prog("selfmod");

        // R8: jumps in right and left slots drop the pending right instruction
        put(0, mk(B_LOAD, 130, B_JMP, 3));
        put(1, mk(B_STORE, 230, B_HALT, 0));
        put(3, mk(B_JMP, 5, B_STORE, 231));
        put(5, mk(B_STORE, 232, B_HALT, 0));
        put(130, 40'h12_3456_789A);
        put_done();
        run_prog("jump");

        // R9: conditional jump on negative (not taken) and zero (taken)
        put(0, mk(B_LOAD, 140, B_JGE, 4));
        put(1, mk(B_STORE, 240, B_LOAD, 141));
        put(2, mk(B_JGE, 6, B_STORE, 241));
        put(4, mk(B_STORE, 243, B_HALT, 0));
        put(6, mk(B_STORE, 242, B_HALT, 0));
        put(140, -40'd1);
        put(141, 40'd0);
        put_done();
        run_prog("jge");

        // R10: unknown opcode in the right slot halts at word 0
        put(0, mk(B_LOAD, 150, B_BAD, 0));
        put(1, mk(B_STORE, 250, B_HALT, 0));
        put(150, 40'h55);
        put_done();
        run_prog("badop");

        // R4: counter wraps from the last word back to 0
        put(0, mk(B_JGE, 4095, B_HALT, 0));
        put(4095, mk(B_LOAD, 160, B_STORE, 260));
        put(160, -40'd5);
        put_done();
        run_prog("wrap");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule